// File: doc/BRIEF.md
# Fastlock Timeout Controller

This block decides, for one PLL channel, when the loop runs in its fast-acquisition state. In that state the charge pump runs at its high current setting, and an open-drain output is switched on to place a second resistor in parallel with the loop-filter resistor. Together these widen the loop bandwidth and keep it stable. The block leaves the fast state by itself after a programmed number of phase-comparison cycles.

In automatic mode a start event opens a window. The start event is a register write of a new feedback divide value. The length of the window comes from a timeout register, and a down-counter that steps on each phase-comparison strobe times it. In manual mode the window counter is held clear and a gain bit drives the high-gain setting directly. The open-drain output is used only when its pin is configured as a fastlock output. When the pin is not configured that way, the output stays released so the pin is free for its other use.

Top module: `fastlock_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high with automatic mode selected, `cp_gain_hi`, `fl_sink_en` and `fast_state` are all 0. Reset is asynchronous and clears an open window at once.
- R2: With `auto_mode` = 0 (manual), `cp_gain_hi` and `fast_state` follow `gain_sel` in the same cycle. A `gain_sel` of 0 selects the low (steady) current and 1 selects the high current, nominally four times the low one. `load_n_evt` has no effect in this mode.
- R3: With `auto_mode` = 1, a `load_n_evt` pulse sampled with a nonzero `timeout_val` T opens the fast state from the cycle after that clock edge. In this mode `gain_sel` is ignored.
- R4: The window counter decreases by one on each clock edge where `cmp_strobe` is high. It holds its value on edges without a strobe. The fast state therefore lasts exactly T strobes, however those strobes are spaced.
- R5: On the edge that takes the T-th strobe, the block returns to steady state. From the next cycle `cp_gain_hi`, `fl_sink_en` and `fast_state` are 0. Further strobes then have no effect.
- R6: A `load_n_evt` sampled with `timeout_val` = 0 opens no fast state. If a window is open, it closes that window from the next cycle.
- R7: A `load_n_evt` during an open window reloads the counter with the current `timeout_val` and restarts the window. If `load_n_evt` and `cmp_strobe` share an edge, the load wins and no count is lost.
- R8: `fl_sink_en` is 1 exactly when `fast_state` is 1 and `pin_as_fl` is 1. With `pin_as_fl` = 0 the sink stays off while the charge-pump gain still follows the fast state.
- R9: Selecting manual mode clears the window counter. After a return to automatic mode, no fast state is present until a new `load_n_evt` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_strobe | input | 1 | One-cycle pulse per phase-comparison cycle |
| load_n_evt | input | 1 | Start event: new feedback divide value written |
| timeout_val | input | TMO_W | Window length in phase-comparison cycles (0 disables) |
| auto_mode | input | 1 | 1 = automatic timed window, 0 = manual gain control |
| gain_sel | input | 1 | Manual gain bit: 0 low current, 1 high current |
| pin_as_fl | input | 1 | Output pin configured as fastlock output |
| cp_gain_hi | output | 1 | Charge-pump high-current select |
| fl_sink_en | output | 1 | Open-drain pull-down enable for the parallel resistor |
| fast_state | output | 1 | High while the channel is in the fast state |

## Verification
The bench builds the block with `TMO_W` = 4. With that width the full-scale timeout of 15 can be counted out strobe by strobe within a short run, and the all-ones reload value is checked directly. The narrow counter also makes the last-strobe edge and the one-count window (T = 1) easy to reach. These sit next to the T = 0 case, where no fast state may open. The vector table interleaves idle cycles with strobes, coincident load and strobe edges, and mode and pin-configuration changes in the middle of a window.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic {
    FL_MANUAL = 1'b0,
    FL_AUTO   = 1'b1
  } fl_mode_e;

  typedef struct packed {
    logic cp_hi;
    logic sink_en;
    logic fast;
  } fl_drive_t;

endpackage

// File: rtl/fl_window_counter.sv
module fl_window_counter #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             strobe_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             active_o,
  output logic             expire_o
);

  localparam logic [TMO_W-1:0] CNT_ZERO = '0;
  localparam logic [TMO_W-1:0] CNT_ONE  = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;

  // Priority: mode clear, then load, then strobe-driven decrement.
  function automatic logic [TMO_W-1:0] next_count(
    input logic [TMO_W-1:0] cur,
    input logic [TMO_W-1:0] tmo,
    input logic             clr,
    input logic             start,
    input logic             strobe
  );
    if (clr)                          return CNT_ZERO;
    if (start)                        return tmo;
    if (strobe && (cur != CNT_ZERO))  return cur - CNT_ONE;
    return cur;
  endfunction

  assign cnt_d    = next_count(cnt_q, tmo_i, clr_i, start_i, strobe_i);
  assign active_o = (cnt_q != CNT_ZERO);
  assign expire_o = strobe_i && !start_i && !clr_i && (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= cnt_d;
  end

  // R4: without a strobe, load or clear the count holds
  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !start_i && !strobe_i) |=> $stable(cnt_q));

  // R4: a strobe on an open window takes exactly one count away
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !start_i && strobe_i && (cnt_q != CNT_ZERO)) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R7: a load takes the timeout value even when a strobe shares the edge
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && start_i) |=> (cnt_q == $past(tmo_i)));

  // R6: a zero timeout leaves no window open
  a_r6_zero_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && start_i && (tmo_i == CNT_ZERO)) |=> !active_o);

  // R9: manual mode empties the counter
  a_r9_manual_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == CNT_ZERO));

endmodule

// File: rtl/fl_drive_select.sv
module fl_drive_select
  import fl_pkg::*;
(
  input  fl_mode_e  mode_i,
  input  logic      gain_i,
  input  logic      win_active_i,
  input  logic      pin_cfg_i,
  output fl_drive_t drive_o
);

  logic fast_w;

  // Manual: the gain bit rules; automatic: the timed window rules.
  always_comb begin
    unique case (mode_i)
      FL_MANUAL: fast_w = gain_i;
      FL_AUTO:   fast_w = win_active_i;
      default:   fast_w = 1'b0;
    endcase
  end

  assign drive_o.fast    = fast_w;
  assign drive_o.cp_hi   = fast_w;
  assign drive_o.sink_en = fast_w && pin_cfg_i;

endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
  import fl_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_strobe,
  input  logic             load_n_evt,
  input  logic [TMO_W-1:0] timeout_val,
  input  logic             auto_mode,
  input  logic             gain_sel,
  input  logic             pin_as_fl,
  output logic             cp_gain_hi,
  output logic             fl_sink_en,
  output logic             fast_state
);

  fl_mode_e  mode_w;
  logic      win_clr_w;
  logic      win_active_w;
  logic      win_expire_w;
  fl_drive_t drive_w;

  assign mode_w    = fl_mode_e'(auto_mode);
  assign win_clr_w = (mode_w == FL_MANUAL);

  fl_window_counter #(.TMO_W(TMO_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (win_clr_w),
    .start_i  (load_n_evt),
    .strobe_i (cmp_strobe),
    .tmo_i    (timeout_val),
    .active_o (win_active_w),
    .expire_o (win_expire_w)
  );

  fl_drive_select u_drive (
    .mode_i       (mode_w),
    .gain_i       (gain_sel),
    .win_active_i (win_active_w),
    .pin_cfg_i    (pin_as_fl),
    .drive_o      (drive_w)
  );

  assign cp_gain_hi = drive_w.cp_hi;
  assign fl_sink_en = drive_w.sink_en;
  assign fast_state = drive_w.fast;

  // R5: the last strobe of a window closes it on the following cycle
  a_r5_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire_w |=> !win_active_w);

  // R3: a load with a nonzero timeout in automatic mode opens a window
  a_r3_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && load_n_evt && (timeout_val != '0)) |=> win_active_w);

endmodule

// File: tb/fastlock_ctrl_bench.sv
module fastlock_ctrl_bench;

  localparam int TW = 4;
  localparam int NV = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_strobe = 1'b0;
  logic          load_n_evt = 1'b0;
  logic [TW-1:0] timeout_val = '0;
  logic          auto_mode = 1'b1;
  logic          gain_sel = 1'b0;
  logic          pin_as_fl = 1'b1;
  logic          cp_gain_hi, fl_sink_en, fast_state;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fastlock_ctrl #(.TMO_W(TW)) u_fastlock_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe), .load_n_evt(load_n_evt),
    .timeout_val(timeout_val), .auto_mode(auto_mode), .gain_sel(gain_sel),
    .pin_as_fl(pin_as_fl), .cp_gain_hi(cp_gain_hi), .fl_sink_en(fl_sink_en),
    .fast_state(fast_state)
  );

  // {auto, gain, pin, load, strobe, tmo[3:0], exp gain_hi, exp sink, exp fast}
  localparam logic [11:0] VEC [NV] = '{
    {5'b10110, 4'd3,  3'b111},  // R3 open T=3
    {5'b10100, 4'd3,  3'b111},  // R4 idle holds
    {5'b10101, 4'd0,  3'b111},  // R4 step 3->2
    {5'b10101, 4'd0,  3'b111},  // R4 step 2->1
    {5'b10101, 4'd0,  3'b000},  // R5 last strobe closes
    {5'b10101, 4'd0,  3'b000},  // R5 extra strobe no effect
    {5'b10111, 4'd2,  3'b111},  // R7 load with strobe, load wins
    {5'b10101, 4'd0,  3'b111},  // R7 2->1
    {5'b10110, 4'd4,  3'b111},  // R7 restart T=4
    {5'b10101, 4'd0,  3'b111},  // R7 4->3
    {5'b10101, 4'd0,  3'b111},  // R7 3->2
    {5'b10101, 4'd0,  3'b111},  // R7 2->1
    {5'b10101, 4'd0,  3'b000},  // R5 restart window ends
    {5'b10110, 4'd0,  3'b000},  // R6 zero timeout no window
    {5'b10010, 4'd2,  3'b101},  // R8 pin unrouted: sink off
    {5'b11001, 4'd0,  3'b101},  // R8 R3 gain bit ignored in auto
    {5'b10110, 4'd0,  3'b000},  // R6 zero load ends open window
    {5'b10110, 4'd15, 3'b111},  // R3 full-scale load
    {5'b00100, 4'd0,  3'b000},  // R9 R2 manual gain 0
    {5'b01100, 4'd0,  3'b111},  // R2 manual gain 1
    {5'b01010, 4'd5,  3'b101},  // R2 R8 load ignored, pin unrouted
    {5'b11100, 4'd0,  3'b000},  // R9 back to auto: no window
    {5'b11110, 4'd1,  3'b111},  // R3 one-count window
    {5'b10101, 4'd0,  3'b000}   // R5 T=1 closes after one strobe
  };

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {gain_hi,sink,fast} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs low during reset
    repeat (3) @(negedge clk);
    check3("R1", {cp_gain_hi, fl_sink_en, fast_state}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1", {cp_gain_hi, fl_sink_en, fast_state}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      {auto_mode, gain_sel, pin_as_fl, load_n_evt, cmp_strobe} = VEC[i][11:7];
      timeout_val = VEC[i][6:3];
      @(negedge clk);
      check3($sformatf("table row %0d", i), {cp_gain_hi, fl_sink_en, fast_state}, VEC[i][2:0]);
    end

    // R4: full-scale window counted with spaced strobes
    {auto_mode, gain_sel, pin_as_fl, load_n_evt, cmp_strobe} = 5'b10110;
    timeout_val = 4'd15;
    @(negedge clk);
    load_n_evt = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 60; k++) begin
        cmp_strobe = (k % 2 == 1);
        @(negedge clk);
        if (cmp_strobe) seen++;
        if (!fast_state) break;
      end
      check_int("R4", seen, 15);
    end
    cmp_strobe = 1'b0;

    // R1: reset clears an open window at once
    load_n_evt = 1'b1;
    timeout_val = 4'd5;
    @(negedge clk);
    load_n_evt = 1'b0;
    check3("R3", {cp_gain_hi, fl_sink_en, fast_state}, 3'b111);
    rst_n = 1'b0;
    #1;
    check3("R1", {cp_gain_hi, fl_sink_en, fast_state}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1", {cp_gain_hi, fl_sink_en, fast_state}, 3'b000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule